// File: doc/BRIEF.md
# Machine Cycle Timing Sequencer

This block produces the internal timing for a small 8-bit controller core. Every machine cycle is twelve clocks long: six states, S1 to S6, each split into a first and a second phase. From the running state and phase it generates the address latch enable pulses and the code-fetch strobe. It also produces the latch enables for the opcode and operand registers, the program counter advance, the window in which external data memory is addressed, and a pulse when an instruction ends.

A simple opcode decoder drives three inputs: whether the instruction is two bytes long, how many machine cycles it needs (one, two or four), and whether it moves data to or from external data memory. The sequencer samples them once, in the clock where the opcode is latched. From those values it decides whether the second code byte of the cycle is kept, how many cycles to run, and whether the code fetches of the second cycle give way to the external data window.

The tick state machine walks T_S1P1 through T_S6P2 and wraps from T_S6P2 to T_S1P1. The instruction state machine has three states. IS_FIRST is the opening cycle, where bytes are latched. IS_EXTRA is a later cycle whose fetches are thrown away. IS_XDATA is the second cycle of an external data move. The transitions all occur at the end of T_S6P2. IS_FIRST goes to IS_EXTRA or IS_XDATA when more cycles remain. IS_EXTRA stays in IS_EXTRA while cycles remain. IS_EXTRA and IS_XDATA go back to IS_FIRST after the last cycle, and IS_FIRST stays in IS_FIRST for a one-cycle instruction.

Top module: `mcyc_sequencer`

## Requirements
- R1: After reset the outputs show state_idx=0 and phase_idx=0 (S1, first phase). The pair advances by one phase each clock: phase 0 to 1 within a state, then to phase 0 of the next state, and from state 5 phase 1 back to state 0 phase 0.
- R2: ale is high in exactly four ticks of a cycle: S1 phase 1, S2 phase 0, S4 phase 1 and S5 phase 0. The only exception is the second cycle of an external data move, where it stays low.
- R3: code_fetch is high during all of S1 and all of S4 (both phases) in every cycle except the second cycle of an external data move.
- R4: opcode_le and pc_inc are high together at S1 phase 1 of the first cycle of each instruction, and opcode_le is never high elsewhere.
- R5: In the first cycle of a two-byte instruction (dec_len2=1), operand_le and pc_inc are high at S4 phase 1. For a one-byte instruction the S4 byte is discarded: operand_le and pc_inc stay low there.
- R6: dec_cycles selects the length: 2'b00 gives one cycle, 2'b01 two, and 2'b10 or 2'b11 four. Cycles after the first still fetch but never assert opcode_le, operand_le or pc_inc.
- R7: instr_done is a one-clock pulse at S6 phase 1 of the final cycle, and the next clock is S1 phase 0 of the next instruction.
- R8: When dec_xmove=1 the instruction is one byte and two cycles long, whatever dec_len2 and dec_cycles hold. Throughout its second cycle xdata_win is high on all twelve clocks, and code_fetch and ale stay low.
- R9: The decoder inputs are sampled only at S1 phase 1 of the first cycle. Values on them at any other clock do not change pc_inc, operand_le, the instruction length or any other output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_len2 | input | 1 | Decoder: instruction is two bytes |
| dec_cycles | input | 2 | Decoder: cycle count code (00=1, 01=2, 1x=4) |
| dec_xmove | input | 1 | Decoder: external data memory move |
| state_idx | output | 3 | Current state, 0..5 for S1..S6 |
| phase_idx | output | 1 | Current phase, 0 first, 1 second |
| ale | output | 1 | Address latch enable |
| code_fetch | output | 1 | Program memory fetch strobe |
| opcode_le | output | 1 | Opcode register latch enable |
| operand_le | output | 1 | Operand register latch enable |
| pc_inc | output | 1 | Program counter advance |
| xdata_win | output | 1 | External data address/strobe window |
| instr_done | output | 1 | Final clock of the instruction |

## Verification
The bound checker checks the phase and state stepping on every clock. It also checks that ale and instr_done land only in their allowed ticks, that the operand latch falls at S4 with a counter advance, that the external data window excludes fetch and ale, and that an opcode latch follows two clocks after every instr_done. Whether ale and the fetch strobe are present or absent in a given cycle depends on which instruction is running. So do the discarded second fetch, the number of cycles, and the insensitivity to decoder inputs outside the sampling tick. Only the bench's per-clock reference model, driven through mixed instruction sequences with noise on the decoder inputs, can show these.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    parameter int STATES_PER_CYCLE = 6;
    parameter int PHASES_PER_STATE = 2;
    localparam int TICKS_PER_CYCLE = STATES_PER_CYCLE * PHASES_PER_STATE;
    localparam int TICK_W  = $clog2(TICKS_PER_CYCLE);
    localparam int STATE_W = $clog2(STATES_PER_CYCLE);
    localparam int CYC_W   = 2;

    typedef enum logic [TICK_W-1:0] {
        T_S1P1 = 4'd0,  T_S1P2 = 4'd1,
        T_S2P1 = 4'd2,  T_S2P2 = 4'd3,
        T_S3P1 = 4'd4,  T_S3P2 = 4'd5,
        T_S4P1 = 4'd6,  T_S4P2 = 4'd7,
        T_S5P1 = 4'd8,  T_S5P2 = 4'd9,
        T_S6P1 = 4'd10, T_S6P2 = 4'd11
    } tick_e;

    typedef enum logic [1:0] {
        IS_FIRST = 2'd0,
        IS_EXTRA = 2'd1,
        IS_XDATA = 2'd2
    } istate_e;

endpackage

// File: rtl/mcyc_tick_fsm.sv
module mcyc_tick_fsm
    import mcyc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output tick_e               tick,
    output logic [STATE_W-1:0]  state_idx,
    output logic                phase_idx
);

    tick_e tick_q;
    tick_e tick_d;

    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= T_S1P1;
        else        tick_q <= tick_d;
    end

    always_comb begin
        unique case (tick_q)
            T_S1P1:  tick_d = T_S1P2;
            T_S1P2:  tick_d = T_S2P1;
            T_S2P1:  tick_d = T_S2P2;
            T_S2P2:  tick_d = T_S3P1;
            T_S3P1:  tick_d = T_S3P2;
            T_S3P2:  tick_d = T_S4P1;
            T_S4P1:  tick_d = T_S4P2;
            T_S4P2:  tick_d = T_S5P1;
            T_S5P1:  tick_d = T_S5P2;
            T_S5P2:  tick_d = T_S6P1;
            T_S6P1:  tick_d = T_S6P2;
            T_S6P2:  tick_d = T_S1P1;
            default: tick_d = T_S1P1;
        endcase
    end

    always_comb begin
        tick = tick_q;
        unique case (tick_q)
            T_S1P1, T_S1P2: state_idx = STATE_W'(0);
            T_S2P1, T_S2P2: state_idx = STATE_W'(1);
            T_S3P1, T_S3P2: state_idx = STATE_W'(2);
            T_S4P1, T_S4P2: state_idx = STATE_W'(3);
            T_S5P1, T_S5P2: state_idx = STATE_W'(4);
            T_S6P1, T_S6P2: state_idx = STATE_W'(5);
            default:        state_idx = STATE_W'(0);
        endcase
        phase_idx = tick_q[0];
    end

endmodule

// File: rtl/mcyc_instr_fsm.sv
module mcyc_instr_fsm
    import mcyc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  tick_e       tick,
    input  logic        dec_len2,
    input  logic [1:0]  dec_cycles,
    input  logic        dec_xmove,
    output istate_e     ist,
    output logic        len2_kept,
    output logic        last_cycle
);

    istate_e            ist_q, ist_d;
    logic [CYC_W-1:0]   left_q, left_d;
    logic               len2_q, len2_d;
    logic               xmove_q, xmove_d;
    logic               accept;
    logic               cycle_end;
    logic [CYC_W-1:0]   extra_cycles;

    assign accept    = (ist_q == IS_FIRST) && (tick == T_S1P2);
    assign cycle_end = (tick == T_S6P2);

    always_comb begin
        unique case (dec_cycles)
            2'b00:   extra_cycles = CYC_W'(0);
            2'b01:   extra_cycles = CYC_W'(1);
            default: extra_cycles = CYC_W'(3);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ist_q   <= IS_FIRST;
            left_q  <= '0;
            len2_q  <= 1'b0;
            xmove_q <= 1'b0;
        end else begin
            ist_q   <= ist_d;
            left_q  <= left_d;
            len2_q  <= len2_d;
            xmove_q <= xmove_d;
        end
    end

    always_comb begin
        ist_d   = ist_q;
        left_d  = left_q;
        len2_d  = len2_q;
        xmove_d = xmove_q;
        if (accept) begin
            xmove_d = dec_xmove;
            len2_d  = dec_len2 && !dec_xmove;
            left_d  = dec_xmove ? CYC_W'(1) : extra_cycles;
        end else if (cycle_end && (left_q != '0)) begin
            left_d = left_q - CYC_W'(1);
        end
        unique case (ist_q)
            IS_FIRST: begin
                if (cycle_end && (left_q != '0))
                    ist_d = xmove_q ? IS_XDATA : IS_EXTRA;
            end
            IS_EXTRA: begin
                if (cycle_end && (left_q == '0))
                    ist_d = IS_FIRST;
            end
            IS_XDATA: begin
                if (cycle_end && (left_q == '0))
                    ist_d = IS_FIRST;
            end
            default: ist_d = IS_FIRST;
        endcase
    end

    assign ist        = ist_q;
    assign len2_kept  = len2_q;
    assign last_cycle = (left_q == '0);

endmodule

// File: rtl/mcyc_strobe_gen.sv
module mcyc_strobe_gen
    import mcyc_pkg::*;
(
    input  tick_e    tick,
    input  istate_e  ist,
    input  logic     len2_kept,
    input  logic     last_cycle,
    output logic     ale,
    output logic     code_fetch,
    output logic     opcode_le,
    output logic     operand_le,
    output logic     pc_inc,
    output logic     xdata_win,
    output logic     instr_done
);

    logic ale_slot;
    logic fetch_slot;
    logic bus_to_code;

    always_comb begin
        unique case (tick)
            T_S1P2, T_S2P1, T_S4P2, T_S5P1: ale_slot = 1'b1;
            default:                        ale_slot = 1'b0;
        endcase
        unique case (tick)
            T_S1P1, T_S1P2, T_S4P1, T_S4P2: fetch_slot = 1'b1;
            default:                        fetch_slot = 1'b0;
        endcase
    end

    always_comb begin
        bus_to_code = (ist != IS_XDATA);
        ale         = bus_to_code && ale_slot;
        code_fetch  = bus_to_code && fetch_slot;
        opcode_le   = (ist == IS_FIRST) && (tick == T_S1P2);
        operand_le  = (ist == IS_FIRST) && (tick == T_S4P2) && len2_kept;
        pc_inc      = opcode_le || operand_le;
        xdata_win   = (ist == IS_XDATA);
        instr_done  = (tick == T_S6P2) && last_cycle;
    end

endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
    import mcyc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dec_len2,
    input  logic [1:0]  dec_cycles,
    input  logic        dec_xmove,
    output logic [2:0]  state_idx,
    output logic        phase_idx,
    output logic        ale,
    output logic        code_fetch,
    output logic        opcode_le,
    output logic        operand_le,
    output logic        pc_inc,
    output logic        xdata_win,
    output logic        instr_done
);

    tick_e   tick;
    istate_e ist;
    logic    len2_kept;
    logic    last_cycle;

    mcyc_tick_fsm u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .state_idx (state_idx),
        .phase_idx (phase_idx)
    );

    mcyc_instr_fsm u_instr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .dec_len2   (dec_len2),
        .dec_cycles (dec_cycles),
        .dec_xmove  (dec_xmove),
        .ist        (ist),
        .len2_kept  (len2_kept),
        .last_cycle (last_cycle)
    );

    mcyc_strobe_gen u_strobe (
        .tick       (tick),
        .ist        (ist),
        .len2_kept  (len2_kept),
        .last_cycle (last_cycle),
        .ale        (ale),
        .code_fetch (code_fetch),
        .opcode_le  (opcode_le),
        .operand_le (operand_le),
        .pc_inc     (pc_inc),
        .xdata_win  (xdata_win),
        .instr_done (instr_done)
    );

endmodule

// File: rtl/mcyc_sequencer_checker.sv
module mcyc_sequencer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  state_idx,
    input logic        phase_idx,
    input logic        ale,
    input logic        code_fetch,
    input logic        opcode_le,
    input logic        operand_le,
    input logic        pc_inc,
    input logic        xdata_win,
    input logic        instr_done
);

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_idx == 1'b0) |=> (phase_idx == 1'b1 && state_idx == $past(state_idx))); // R1

    AST_STATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_idx == 1'b1 && state_idx != 3'd5) |=> (phase_idx == 1'b0 && state_idx == $past(state_idx) + 3'd1)); // R1

    AST_CYCLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_idx == 1'b1 && state_idx == 3'd5) |=> (phase_idx == 1'b0 && state_idx == 3'd0)); // R1

    AST_ALE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ((state_idx == 3'd0 && phase_idx) || (state_idx == 3'd1 && !phase_idx) ||
                 (state_idx == 3'd3 && phase_idx) || (state_idx == 3'd4 && !phase_idx))); // R2

    AST_OPCODE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        opcode_le |-> (state_idx == 3'd0 && phase_idx && pc_inc)); // R4

    AST_OPERAND_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        operand_le |-> (state_idx == 3'd3 && phase_idx && pc_inc)); // R5

    AST_DONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> (state_idx == 3'd5 && phase_idx)); // R7

    AST_DONE_THEN_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> ##2 opcode_le); // R7

    AST_XDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        xdata_win |-> (!code_fetch && !ale && !pc_inc)); // R8

endmodule

bind mcyc_sequencer mcyc_sequencer_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_idx  (state_idx),
    .phase_idx  (phase_idx),
    .ale        (ale),
    .code_fetch (code_fetch),
    .opcode_le  (opcode_le),
    .operand_le (operand_le),
    .pc_inc     (pc_inc),
    .xdata_win  (xdata_win),
    .instr_done (instr_done)
);

// File: tb/mcyc_sequencer_bench.sv
module mcyc_sequencer_bench;

    localparam int NI = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dec_len2;
    logic [1:0] dec_cycles;
    logic       dec_xmove;
    logic [2:0] state_idx;
    logic       phase_idx, ale, code_fetch, opcode_le, operand_le;
    logic       pc_inc, xdata_win, instr_done;

    always #2 clk = ~clk;

    mcyc_sequencer u_mcyc_sequencer (
        .clk(clk), .rst_n(rst_n),
        .dec_len2(dec_len2), .dec_cycles(dec_cycles), .dec_xmove(dec_xmove),
        .state_idx(state_idx), .phase_idx(phase_idx), .ale(ale),
        .code_fetch(code_fetch), .opcode_le(opcode_le), .operand_le(operand_le),
        .pc_inc(pc_inc), .xdata_win(xdata_win), .instr_done(instr_done)
    );

    // instruction program: length flag, cycle code, external move flag
    int l2_list [NI] = '{0, 1, 0, 1, 0, 1, 0, 1, 1, 0};
    int cy_list [NI] = '{0, 0, 1, 1, 0, 2, 2, 3, 0, 0};
    int xm_list [NI] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 0};

    int checks = 0;
    int failures = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    initial begin
        int m_t, m_cyc, m_ncyc, m_len2, m_xm, exp_bytes;
        int k, dones, clk_in, pc_seen;
        bit first, xc, e_done;
        logic [15:0] lfsr;
        m_t = 0; m_cyc = 0; m_ncyc = 1; m_len2 = 0; m_xm = 0; exp_bytes = 1;
        k = 0; dones = 0; clk_in = 0; pc_seen = 0;
        lfsr = 16'hACE1;
        rst_n = 1'b0; dec_len2 = 1'b1; dec_cycles = 2'b11; dec_xmove = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "reset state_idx", int'(state_idx), 0);
        chk("R1", "reset phase_idx", int'(phase_idx), 0);
        for (int n = 0; n < 3000 && dones < NI; n++) begin
            // drive decoder inputs for the current tick
            if (m_t == 1 && m_cyc == 0) begin
                dec_len2   = l2_list[k][0];
                dec_cycles = 2'(cy_list[k]);
                dec_xmove  = xm_list[k][0];
                m_xm   = xm_list[k];
                m_len2 = m_xm ? 0 : l2_list[k];
                m_ncyc = m_xm ? 2 : (cy_list[k] == 0 ? 1 : (cy_list[k] == 1 ? 2 : 4));
                exp_bytes = m_len2 + 1;
                k++;
            end else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                dec_len2   = lfsr[0];
                dec_cycles = lfsr[2:1];
                dec_xmove  = lfsr[3];
            end
            first  = (m_cyc == 0);
            xc     = (m_xm != 0) && (m_cyc == 1);
            e_done = (m_t == 11) && (m_cyc == m_ncyc - 1);
            chk("R1", "state_idx", int'(state_idx), m_t / 2);
            chk("R1", "phase_idx", int'(phase_idx), m_t % 2);
            chk("R2", "ale", int'(ale), int'(!xc && (m_t == 1 || m_t == 2 || m_t == 7 || m_t == 8)));
            chk("R3", "code_fetch", int'(code_fetch), int'(!xc && (m_t == 0 || m_t == 1 || m_t == 6 || m_t == 7)));
            chk("R4", "opcode_le", int'(opcode_le), int'(first && m_t == 1));
            chk("R5", "operand_le", int'(operand_le), int'(first && m_t == 7 && m_len2 != 0));
            chk("R5", "pc_inc", int'(pc_inc), int'(first && (m_t == 1 || (m_t == 7 && m_len2 != 0))));
            chk("R8", "xdata_win", int'(xdata_win), int'(xc));
            chk("R7", "instr_done", int'(instr_done), int'(e_done));
            clk_in++;
            if (pc_inc) pc_seen++;
            if (e_done) begin
                chk("R6", "clocks in instruction", clk_in, 12 * m_ncyc);
                chk("R9", "pc advances in instruction", pc_seen, exp_bytes);
                clk_in = 0; pc_seen = 0; dones++;
            end
            // advance model
            if (m_t == 11) begin
                m_t = 0;
                m_cyc = e_done ? 0 : m_cyc + 1;
            end else begin
                m_t++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        if (dones < NI) begin
            checks++; failures++;
            $display("FAIL R7 watchdog: instructions completed actual=%0d expected=%0d", dones, NI);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule